// File: doc/BRIEF.md
# Static Memory Byte-Lane Controller

This block drives a single external static memory bank whose data width is 8, 16 or 32 bits. A host hands it one request at a time through a valid/ready handshake. Each request carries a byte address, byte enables, a read/write flag and write data. The block then produces the device address, chip select, output enable, a shared write enable and four active-low byte-lane strobes. For reads it returns the data, aligned to the low end of the returned word.

A lane-mode input selects how the strobes are used. With the mode at 0, each strobe is the write enable of one 8-bit device. The strobes pulse only on writes, and only for the addressed bytes, while the shared write enable stays idle. With the mode at 1, the strobes act as byte selects on both reads and writes, and the shared write enable performs the write. Narrow banks always sit on the upper data lanes. A programmable wait count sets the access length, and every access is followed by one idle recovery cycle.

Top module: `smc_lane_ctrl`

## Requirements
- R1: The 21-bit device address is request address bits [22:2] for a 32-bit bank (width code 2 or 3), bits [21:1] for a 16-bit bank (code 1), and bits [20:0] for an 8-bit bank (code 0).
- R2: In a 32-bit bank, host byte enable i controls lane strobe i, and write data bits [31:0] are driven unchanged on the memory data bus.
- R3: A 16-bit bank uses only strobes 3 and 2, driven by byte enables 1 and 0, with write data [15:0] on bus bits [31:16]. An 8-bit bank uses only strobe 3, driven by byte enable 0, with write data [7:0] on bus bits [31:24]. Unused strobes stay high.
- R4: With lane mode 0, all four lane strobes stay high for the whole of a read, while output enable is low.
- R5: With lane mode 0, a write drives low only the strobes of the enabled bytes, and the shared write enable stays high at all times.
- R6: With lane mode 1, the strobes of the enabled bytes are low during both reads and writes, and the shared write enable is low during writes.
- R7: Chip select is low for exactly N cycles per access, where N is the wait setting (1 to 15). A setting of 0 behaves as 1.
- R8: Ready is high when idle. It is low from the acceptance edge through the whole access and through one recovery cycle with chip select high, and it is high again after that cycle.
- R9: On a read, the bus is sampled on the last wait cycle. The response valid flag is high for the single recovery cycle. The response data holds the active lanes moved down to bit 0, with zeros above them.
- R10: While reset is asserted and after it is released, chip select, output enable, write enable and all strobes are high, ready is high and response valid is low.
- R11: Bank width, lane mode and wait count are captured when a request is accepted. Changing them during an access does not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bank width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cfg_lane_mode | input | 1 | 0: strobes are per-device write enables; 1: strobes are byte selects |
| cfg_wait | input | 4 | Wait cycles per access (0 treated as 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Host byte address |
| req_be | input | 4 | Byte enables, bit 0 = lowest byte of the bank unit |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data, low-aligned |
| mem_addr | output | 21 | Device address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Shared write enable, active low |
| mem_lane_n | output | 4 | Byte-lane strobes, active low |
| mem_dout | output | 32 | Data driven to memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 32 | Data read from memory |

## Verification
The bench aims at the points where the two lane modes differ. A read in mode 0 must keep every strobe high. If the design let the strobes follow the byte enables on reads, the lanes would show the enable pattern instead of 4'hF. For narrow banks it checks that byte enable 0 lands on strobe 3 and that read data is shifted down. A design that used the low lanes would pulse the wrong strobe and return zero or the wrong bytes. A wait setting of 0 and the maximum of 15 test the cycle counter at both limits, where an off-by-one shows up as a wrong chip-select length. Changing the configuration in the middle of an access shows whether the design re-reads live inputs: it would move the address or flip the strobe mode partway through the access.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int LANES      = 4;
    localparam int DATA_W     = LANES * 8;
    localparam int HADDR_W    = 23;
    localparam int DEV_ADDR_W = 21;
    localparam int WAIT_W     = 4;

    typedef enum logic [1:0] {
        BW8  = 2'd0,
        BW16 = 2'd1,
        BW32 = 2'd2,
        BW32B = 2'd3
    } bank_w_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [WAIT_W-1:0]   cnt;
        logic                write;
        bank_w_e             width;
        logic                mode;
        logic [HADDR_W-1:0]  addr;
        logic [LANES-1:0]    be;
        logic [DATA_W-1:0]   wdata;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rdata;
    } smc_state_t;
endpackage

// File: rtl/smc_addr_map.sv
module smc_addr_map
    import smc_pkg::*;
#(
    parameter int AW_IN  = HADDR_W,
    parameter int AW_OUT = DEV_ADDR_W
) (
    input  bank_w_e           width,
    input  logic [AW_IN-1:0]  host_addr,
    output logic [AW_OUT-1:0] dev_addr
);
    localparam int SH_W = 2;

    logic [SH_W-1:0] shift;

    always_comb begin
        case (width)
            BW8:     shift = 2'd0;
            BW16:    shift = 2'd1;
            default: shift = 2'd2;
        endcase
    end

    always_comb begin
        dev_addr = '0;
        case (shift)
            2'd0:    dev_addr = host_addr[0 +: AW_OUT];
            2'd1:    dev_addr = host_addr[1 +: AW_OUT];
            default: dev_addr = host_addr[2 +: AW_OUT];
        endcase
    end
endmodule

// File: rtl/smc_lane_gen.sv
module smc_lane_gen
    import smc_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic          active,
    input  logic          write,
    input  logic          mode,
    input  bank_w_e       width,
    input  logic [NL-1:0] be,
    output logic [NL-1:0] lane_n
);
    localparam int HALF = NL / 2;

    logic [NL-1:0] sel_d;
    logic          lane_act_d;

    always_comb begin
        sel_d = '0;
        case (width)
            BW8:     sel_d[NL-1] = be[0];
            BW16:    sel_d[NL-1 -: HALF] = be[HALF-1:0];
            default: sel_d = be;
        endcase
        lane_act_d = active && (mode || write);
    end

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lane_n[i] = ~(lane_act_d & sel_d[i]);
    end
endmodule

// File: rtl/smc_data_align.sv
module smc_data_align
    import smc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  bank_w_e         width,
    input  logic [DW-1:0]   host_wdata,
    input  logic [DW-1:0]   bus_din,
    output logic [DW-1:0]   bus_dout,
    output logic [DW-1:0]   host_rdata
);
    localparam int HW = DW / 2;
    localparam int BW = 8;

    always_comb begin
        bus_dout   = '0;
        host_rdata = '0;
        case (width)
            BW8: begin
                bus_dout[DW-1 -: BW]  = host_wdata[BW-1:0];
                host_rdata[BW-1:0]    = bus_din[DW-1 -: BW];
            end
            BW16: begin
                bus_dout[DW-1 -: HW]  = host_wdata[HW-1:0];
                host_rdata[HW-1:0]    = bus_din[DW-1 -: HW];
            end
            default: begin
                bus_dout   = host_wdata;
                host_rdata = bus_din;
            end
        endcase
    end
endmodule

// File: rtl/smc_lane_ctrl.sv
module smc_lane_ctrl
    import smc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_width,
    input  logic                  cfg_lane_mode,
    input  logic [WAIT_W-1:0]     cfg_wait,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [HADDR_W-1:0]    req_addr,
    input  logic [LANES-1:0]      req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [DEV_ADDR_W-1:0] mem_addr,
    output logic                  mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [LANES-1:0]      mem_lane_n,
    output logic [DATA_W-1:0]     mem_dout,
    output logic                  mem_dout_en,
    input  logic [DATA_W-1:0]     mem_din
);
    smc_state_t          st_d, st_q;
    logic                active;
    logic [DATA_W-1:0]   rd_aligned;
    logic [WAIT_W-1:0]   wait_eff;

    assign active = (st_q.phase == PH_ACTIVE);
    assign wait_eff = (cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = wait_eff - WAIT_W'(1);
                    st_d.write = req_write;
                    st_d.width = bank_w_e'(cfg_width);
                    st_d.mode  = cfg_lane_mode;
                    st_d.addr  = req_addr;
                    st_d.be    = req_be;
                    st_d.wdata = req_wdata;
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RECOVER;
                    if (!st_q.write) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rdata     = rd_aligned;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - WAIT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, width: BW32, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    smc_addr_map u_addr (
        .width     (st_q.width),
        .host_addr (st_q.addr),
        .dev_addr  (mem_addr)
    );

    smc_lane_gen u_lane (
        .active (active),
        .write  (st_q.write),
        .mode   (st_q.mode),
        .width  (st_q.width),
        .be     (st_q.be),
        .lane_n (mem_lane_n)
    );

    smc_data_align u_align (
        .width      (st_q.width),
        .host_wdata (st_q.wdata),
        .bus_din    (mem_din),
        .bus_dout   (mem_dout),
        .host_rdata (rd_aligned)
    );

    assign req_ready   = (st_q.phase == PH_IDLE);
    assign mem_cs_n    = ~active;
    assign mem_oe_n    = ~(active && !st_q.write);
    assign mem_we_n    = ~(active && st_q.write && st_q.mode);
    assign mem_dout_en = active && st_q.write;
    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_rdata   = st_q.rdata;

    // R4
    rd_lanes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !st_q.mode) |-> (mem_lane_n == '1));

    // R5
    we_idle_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> mem_we_n);

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R3
    narrow8_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && st_q.width == BW8) |-> (mem_lane_n[2:0] == 3'b111));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    // R8
    recover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n ##1 mem_cs_n) |-> !req_ready);

    // R9
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n ##1 !mem_cs_n) |-> $stable(mem_addr));
endmodule

// File: tb/smc_lane_ctrl_test.sv
module smc_lane_ctrl_test;
    typedef struct packed {
        logic        wr;
        logic [1:0]  width;
        logic        mode;
        logic [3:0]  wt;
        logic [4:0]  ncyc;
        logic [22:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] din;
        logic [20:0] eaddr;
        logic [3:0]  elane;
        logic        ewe;
        logic        eoe;
        logic [31:0] edout;
        logic [31:0] erdata;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 2'd2, 1'b0, 4'd2,  5'd2,  23'h12345C, 4'b0101, 32'hA1B2C3D4, 32'h0,        21'h048D17, 4'hA, 1'b1, 1'b1, 32'hA1B2C3D4, 32'h0},
        '{1'b0, 2'd2, 1'b0, 4'd3,  5'd3,  23'h000010, 4'b1111, 32'h0,        32'h11223344, 21'h000004, 4'hF, 1'b1, 1'b0, 32'h0,        32'h11223344},
        '{1'b1, 2'd1, 1'b0, 4'd1,  5'd1,  23'h2AAAAA, 4'b0010, 32'h0000BEEF, 32'h0,        21'h155555, 4'h7, 1'b1, 1'b1, 32'hBEEF0000, 32'h0},
        '{1'b0, 2'd1, 1'b0, 4'd2,  5'd2,  23'h000006, 4'b0011, 32'h0,        32'hCAFE1234, 21'h000003, 4'hF, 1'b1, 1'b0, 32'h0,        32'h0000CAFE},
        '{1'b1, 2'd0, 1'b0, 4'd4,  5'd4,  23'h1FFFFF, 4'b0001, 32'h0000005A, 32'h0,        21'h1FFFFF, 4'h7, 1'b1, 1'b1, 32'h5A000000, 32'h0},
        '{1'b0, 2'd0, 1'b0, 4'd1,  5'd1,  23'h7FFFFF, 4'b0001, 32'h0,        32'h9C000000, 21'h1FFFFF, 4'hF, 1'b1, 1'b0, 32'h0,        32'h0000009C},
        '{1'b1, 2'd2, 1'b1, 4'd2,  5'd2,  23'h400000, 4'b1100, 32'h01020304, 32'h0,        21'h100000, 4'h3, 1'b0, 1'b1, 32'h01020304, 32'h0},
        '{1'b0, 2'd3, 1'b1, 4'd2,  5'd2,  23'h000008, 4'b0110, 32'h0,        32'hDEADBEEF, 21'h000002, 4'h9, 1'b1, 1'b0, 32'h0,        32'hDEADBEEF},
        '{1'b0, 2'd1, 1'b1, 4'd3,  5'd3,  23'h000002, 4'b0001, 32'h0,        32'h77770000, 21'h000001, 4'hB, 1'b1, 1'b0, 32'h0,        32'h00007777},
        '{1'b1, 2'd0, 1'b1, 4'd15, 5'd15, 23'h000003, 4'b0001, 32'h000000FF, 32'h0,        21'h000003, 4'h7, 1'b0, 1'b1, 32'hFF000000, 32'h0},
        '{1'b1, 2'd2, 1'b0, 4'd0,  5'd1,  23'h000004, 4'b1111, 32'h00000000, 32'h0,        21'h000001, 4'h0, 1'b1, 1'b1, 32'h00000000, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd2;
    logic        cfg_lane_mode = 1'b0;
    logic [3:0]  cfg_wait = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [20:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [3:0]  mem_lane_n;
    logic [31:0] mem_dout;
    logic [31:0] mem_din = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smc_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_lane_mode(cfg_lane_mode),
        .cfg_wait(cfg_wait), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int ncyc;
        string lt;
        lt = v.mode ? "R6" : (v.width == 2'd0 || v.width == 2'd1) ? "R3" : (v.wr ? "R5" : "R4");
        @(negedge clk);
        cfg_width = v.width; cfg_lane_mode = v.mode; cfg_wait = v.wt;
        req_write = v.wr; req_addr = v.addr; req_be = v.be; req_wdata = v.wdata;
        mem_din = v.din; req_valid = 1'b1;
        chk($sformatf("R8 v%0d ready idle", idx), 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk($sformatf("R1 v%0d addr", idx), 32'(mem_addr), 32'(v.eaddr));
        chk($sformatf("%s v%0d lanes", lt, idx), 32'(mem_lane_n), 32'(v.elane));
        chk($sformatf("%s v%0d we_n", v.mode ? "R6" : "R5", idx), 32'(mem_we_n), 32'(v.ewe));
        chk($sformatf("R4 v%0d oe_n", idx), 32'(mem_oe_n), 32'(v.eoe));
        chk($sformatf("R8 v%0d ready busy", idx), 32'(req_ready), 32'd0);
        if (v.wr) begin
            chk($sformatf("%s v%0d dout", (v.width >= 2'd2) ? "R2" : "R3", idx), mem_dout, v.edout);
            chk($sformatf("R2 v%0d dout_en", idx), 32'(mem_dout_en), 32'd1);
        end
        ncyc = 1;
        forever begin
            @(negedge clk);
            if (mem_cs_n) break;
            ncyc++;
        end
        chk($sformatf("R7 v%0d cs cycles", idx), 32'(ncyc), 32'(v.ncyc));
        chk($sformatf("R8 v%0d recovery ready", idx), 32'(req_ready), 32'd0);
        chk($sformatf("R9 v%0d rsp_valid", idx), 32'(rsp_valid), 32'(!v.wr));
        if (!v.wr) chk($sformatf("R9 v%0d rdata", idx), rsp_rdata, v.erdata);
        @(negedge clk);
        chk($sformatf("R8 v%0d ready back", idx), 32'(req_ready), 32'd1);
        chk($sformatf("R9 v%0d rsp cleared", idx), 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int ncyc;
        repeat (3) @(negedge clk);
        // R10 during reset
        chk("R10 reset cs_n", 32'(mem_cs_n), 32'd1);
        chk("R10 reset oe/we", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
        chk("R10 reset lanes", 32'(mem_lane_n), 32'hF);
        chk("R10 reset ready/rsp", {30'd0, req_ready, rsp_valid}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset ready", 32'(req_ready), 32'd1);
        chk("R10 after reset cs_n", 32'(mem_cs_n), 32'd1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R11: configuration changed mid-access is ignored
        @(negedge clk);
        cfg_width = 2'd2; cfg_lane_mode = 1'b0; cfg_wait = 4'd3;
        req_write = 1'b0; req_addr = 23'h000100; req_be = 4'b0011;
        mem_din = 32'hA5A5A5A5; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_width = 2'd0; cfg_lane_mode = 1'b1; cfg_wait = 4'd9;
        @(negedge clk);
        chk("R11 addr held", 32'(mem_addr), 32'h40);
        chk("R11 mode held lanes", 32'(mem_lane_n), 32'hF);
        ncyc = 2;
        forever begin
            @(negedge clk);
            if (mem_cs_n) break;
            ncyc++;
        end
        chk("R11 wait held", 32'(ncyc), 32'd3);
        chk("R11 width held rdata", rsp_rdata, 32'hA5A5A5A5);
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule